// File: doc/BRIEF.md
# IP Slot Recovery Timer

This block paces I/O-space and ID-space cycles to four peripheral slots, numbered 0 to 3, on an IndustryPack-style carrier. Each slot has a 2-bit delay code. When an I/O or ID cycle to a slot ends, that slot's down-counter is loaded with the time the code selects. A later I/O or ID request that touches the slot is held until the counter reaches zero. The block runs on the IP clock, so its counts are IP clock cycles.

Double-size (longword) cycles use a slot pair: slots 0 and 1, or slots 2 and 3. Such a cycle loads both counters of its pair. A double-size request is granted only when both counters are zero, whatever kind of access came before it. Memory-space cycles pass through without waiting and leave the counters unchanged.

The block also brings each slot's active-low error input into the clock domain and reports it as an active-high status bit.

Top module: `ip_rcv_timer`

## Requirements
- R1: The delay code for slot i is `rt_cfg_i[2*i+1:2*i]`. Code 00 gives 0 cycles, 01 gives 16, 10 gives 32 and 11 gives 64 (with the default `BASE_CYC` = 16).
- R2: `done_i` with `done_space_i` at I/O (01) or ID (10) and `done_dbl_i` low marks the end of a single cycle to `done_slot_i`. After it, an I/O or ID request to that slot is refused for exactly the coded number of cycles that follow the done cycle.
- R3: The same end marker with `done_dbl_i` high loads both slots of the pair chosen by `done_slot_i[1]`, each from its own code. Bit 0 of the slot number is ignored for double-size requests and done markers.
- R4: A single-size I/O or ID request is granted only while its slot's counter is zero.
- R5: A double-size I/O or ID request is granted only while both counters of its pair are zero. This includes the case where a single-size access to either member came before it.
- R6: A request with `req_space_i` at memory (00) or reserved (11) is granted at once. A done marker with such a space loads no counter.
- R7: `grant_o` is combinational in the request and is low whenever `req_valid_i` is low.
- R8: `err_stat_o[i]` reads 1 exactly when `err_ni[i]` was low, with a delay of two clock edges.
- R9: After reset, all counters are zero and all status bits are 0.
- R10: A new done marker for a slot whose counter is still running reloads it from the code present at that time. The old count is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | IP clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rt_cfg_i | input | 8 | Delay codes, 2 bits per slot |
| req_valid_i | input | 1 | Controller asks to start a cycle |
| req_slot_i | input | 2 | Target slot of the request |
| req_dbl_i | input | 1 | Request is double-size (pair) |
| req_space_i | input | 2 | Address space of the request |
| grant_o | output | 1 | Cycle may start now |
| done_i | input | 1 | A cycle ends in this clock |
| done_slot_i | input | 2 | Slot of the ending cycle |
| done_dbl_i | input | 1 | Ending cycle was double-size |
| done_space_i | input | 2 | Space of the ending cycle |
| err_ni | input | 4 | Slot error inputs, active low |
| err_stat_o | output | 4 | Synchronized error status, active high |

## Verification
On every clock, the assertions check four things. Counters load from the decoded code and count down one step per cycle. A grant for I/O or ID never coincides with a busy slot or busy pair member. Memory requests always pass. The status bits follow the inputs with a two-edge lag.

The exact number of refused cycles for each code, in both single and double size, can only be shown by the bench's scenarios. The same holds for:
- the single-then-double ordering;
- reloading a counter while it is still running;
- the proof that a memory-space end marker leaves the timers idle.

// File: rtl/ip_rcv_pkg.sv
package ip_rcv_pkg;
  typedef enum logic [1:0] {
    SP_MEM = 2'd0,
    SP_IO  = 2'd1,
    SP_ID  = 2'd2,
    SP_RSV = 2'd3
  } space_e;

  function automatic logic needs_rcv(logic [1:0] sp);
    return (sp == SP_IO) || (sp == SP_ID);
  endfunction
endpackage

// File: rtl/ip_rcv_delay_dec.sv
module ip_rcv_delay_dec #(
  parameter int BASE_CYC = 16,
  parameter int CW       = 7
) (
  input  logic [1:0]    code_i,
  output logic [CW-1:0] cyc_o
);
  localparam int MAX_CYC = 4 * BASE_CYC;

  always_comb begin
    unique case (code_i)
      2'd0:    cyc_o = '0;
      2'd1:    cyc_o = CW'(BASE_CYC);
      2'd2:    cyc_o = CW'(2 * BASE_CYC);
      default: cyc_o = CW'(MAX_CYC);
    endcase
  end

  always_comb begin
    AST_DEC_RANGE: assert (int'(cyc_o) <= MAX_CYC); // R1
  end
endmodule

// File: rtl/ip_rcv_slot_cnt.sv
module ip_rcv_slot_cnt #(
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          idle_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign idle_o = (cnt_q == '0);

  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i)); // R2
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R2
  AST_CNT_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && cnt_q != '0) |=> cnt_q == $past(load_val_i)); // R10
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> cnt_q == '0); // R6
endmodule

// File: rtl/ip_rcv_err_sync.sv
module ip_rcv_err_sync #(
  parameter int NSLOT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSLOT-1:0] err_ni,
  output logic [NSLOT-1:0] stat_o
);
  logic [NSLOT-1:0] s1_q, s2_q;
  logic [1:0]       age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= ~err_ni;
      s2_q <= s1_q;
    end
  end

  assign stat_o = s2_q;

  // checker-only age counter, saturates at 2
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd2)  age_q <= age_q + 1'b1;
  end

  AST_ERR_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> stat_o == ~$past(err_ni, 2)); // R8
endmodule

// File: rtl/ip_rcv_grant.sv
module ip_rcv_grant
  import ip_rcv_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int SW    = 2
) (
  input  logic             req_valid_i,
  input  logic [SW-1:0]    req_slot_i,
  input  logic             req_dbl_i,
  input  logic [1:0]       req_space_i,
  input  logic [NSLOT-1:0] idle_i,
  output logic             grant_o
);
  logic [SW-1:0] lo_idx, hi_idx;
  logic          single_ok, pair_ok, timed;

  assign lo_idx    = {req_slot_i[SW-1:1], 1'b0};
  assign hi_idx    = {req_slot_i[SW-1:1], 1'b1};
  assign single_ok = idle_i[req_slot_i];
  assign pair_ok   = idle_i[lo_idx] & idle_i[hi_idx];
  assign timed     = needs_rcv(req_space_i);

  always_comb begin
    grant_o = 1'b0;
    if (req_valid_i) begin
      if (!timed)         grant_o = 1'b1;
      else if (req_dbl_i) grant_o = pair_ok;
      else                grant_o = single_ok;
    end
  end
endmodule

// File: rtl/ip_rcv_timer.sv
module ip_rcv_timer
  import ip_rcv_pkg::*;
#(
  parameter int NSLOT    = 4,
  parameter int BASE_CYC = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2*NSLOT-1:0]   rt_cfg_i,
  input  logic                 req_valid_i,
  input  logic [$clog2(NSLOT)-1:0] req_slot_i,
  input  logic                 req_dbl_i,
  input  logic [1:0]           req_space_i,
  output logic                 grant_o,
  input  logic                 done_i,
  input  logic [$clog2(NSLOT)-1:0] done_slot_i,
  input  logic                 done_dbl_i,
  input  logic [1:0]           done_space_i,
  input  logic [NSLOT-1:0]     err_ni,
  output logic [NSLOT-1:0]     err_stat_o
);
  localparam int SW      = $clog2(NSLOT);
  localparam int MAX_CYC = 4 * BASE_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic [NSLOT-1:0] idle;
  logic             done_timed, req_timed;

  assign done_timed = done_i & needs_rcv(done_space_i);
  assign req_timed  = needs_rcv(req_space_i);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam logic [SW-1:0] IDX = SW'(i);
    logic [CW-1:0] dly;
    logic          hit, load;

    assign hit  = done_dbl_i ? (done_slot_i[SW-1:1] == IDX[SW-1:1])
                             : (done_slot_i == IDX);
    assign load = done_timed & hit;

    ip_rcv_delay_dec #(.BASE_CYC(BASE_CYC), .CW(CW)) u_dec (
      .code_i (rt_cfg_i[2*i +: 2]),
      .cyc_o  (dly)
    );

    ip_rcv_slot_cnt #(.CW(CW)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load),
      .load_val_i (dly),
      .idle_o     (idle[i])
    );
  end

  ip_rcv_grant #(.NSLOT(NSLOT), .SW(SW)) u_grant (
    .req_valid_i (req_valid_i),
    .req_slot_i  (req_slot_i),
    .req_dbl_i   (req_dbl_i),
    .req_space_i (req_space_i),
    .idle_i      (idle),
    .grant_o     (grant_o)
  );

  ip_rcv_err_sync #(.NSLOT(NSLOT)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .err_ni (err_ni),
    .stat_o (err_stat_o)
  );

  logic [SW-1:0] req_lo, req_hi;
  assign req_lo = {req_slot_i[SW-1:1], 1'b0};
  assign req_hi = {req_slot_i[SW-1:1], 1'b1};

  AST_NO_REQ_NO_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !grant_o); // R7
  AST_MEM_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_timed) |-> grant_o); // R6
  AST_SINGLE_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && req_timed && !req_dbl_i) |-> idle[req_slot_i]); // R4
  AST_PAIR_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && req_timed && req_dbl_i) |-> (idle[req_lo] && idle[req_hi])); // R5
  AST_PAIR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_timed && done_dbl_i && rt_cfg_i[2*req_lo +: 2] != 2'd0 &&
     done_slot_i[SW-1:1] == req_lo[SW-1:1]) |=> !idle[req_lo]); // R3
  AST_MEM_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !done_timed && (&idle)) |=> (&idle)); // R6
endmodule

// File: tb/ip_rcv_timer_test.sv
`timescale 1ns/1ps
module ip_rcv_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rt_cfg = '0;
  logic       req_valid = 1'b0;
  logic [1:0] req_slot = '0;
  logic       req_dbl = 1'b0;
  logic [1:0] req_space = '0;
  logic       grant;
  logic       done = 1'b0;
  logic [1:0] done_slot = '0;
  logic       done_dbl = 1'b0;
  logic [1:0] done_space = '0;
  logic [3:0] err_n = 4'hF;
  logic [3:0] err_stat;

  int nvec = 0, nfail = 0;
  string cur_tag = "R9";

  always #2 clk = ~clk;

  ip_rcv_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .rt_cfg_i(rt_cfg),
    .req_valid_i(req_valid), .req_slot_i(req_slot), .req_dbl_i(req_dbl),
    .req_space_i(req_space), .grant_o(grant),
    .done_i(done), .done_slot_i(done_slot), .done_dbl_i(done_dbl),
    .done_space_i(done_space), .err_ni(err_n), .err_stat_o(err_stat)
  );

  // reference model
  int m_cnt[4];
  logic [3:0] e_q[$];

  function automatic int code_cycles(logic [1:0] c);
    case (c)
      2'd0: return 0;
      2'd1: return 16;
      2'd2: return 32;
      default: return 64;
    endcase
  endfunction

  function automatic bit timed(logic [1:0] sp);
    return sp == 2'd1 || sp == 2'd2;
  endfunction

  function automatic bit exp_grant();
    int lo;
    if (!req_valid) return 1'b0;
    if (!timed(req_space)) return 1'b1;
    lo = int'(req_slot) & 2;
    if (req_dbl) return m_cnt[lo] == 0 && m_cnt[lo+1] == 0;
    return m_cnt[req_slot] == 0;
  endfunction

  function automatic logic [3:0] exp_stat();
    return (e_q.size() == 2) ? e_q[0] : 4'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 4; s++) m_cnt[s] = 0;
      e_q.delete();
      e_q.push_back(4'h0);
      e_q.push_back(4'h0);
    end else begin
      for (int s = 0; s < 4; s++) begin
        bit ld;
        ld = done && timed(done_space) &&
             (done_dbl ? ((s & 2) == (int'(done_slot) & 2)) : (s == int'(done_slot)));
        if (ld) m_cnt[s] = code_cycles(rt_cfg[2*s +: 2]);
        else if (m_cnt[s] > 0) m_cnt[s] = m_cnt[s] - 1;
      end
      void'(e_q.pop_front());
      e_q.push_back(~err_n);
    end
  end

  always @(negedge clk) begin
    nvec++;
    if (grant !== exp_grant()) begin
      nfail++;
      $display("FAIL %s grant: got %b expected %b at %0t", cur_tag, grant, exp_grant(), $time);
    end
    nvec++;
    if (err_stat !== exp_stat()) begin
      nfail++;
      $display("FAIL R8 err_stat: got %b expected %b at %0t", err_stat, exp_stat(), $time);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    req_valid = 1'b0; done = 1'b0;
    repeat (70) step();
  endtask

  task automatic end_cycle(int slot, bit dbl, logic [1:0] sp);
    done = 1'b1; done_slot = 2'(slot); done_dbl = dbl; done_space = sp;
    step();
    done = 1'b0;
  endtask

  // count refused cycles of a request raised right after the done cycle
  task automatic wait_count(int slot, bit dbl, logic [1:0] sp, output int n);
    req_valid = 1'b1; req_slot = 2'(slot); req_dbl = dbl; req_space = sp;
    n = 0;
    forever begin
      @(negedge clk);
      if (grant) break;
      n++;
      if (n > 300) break;
    end
    step();
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) step();
    cur_tag = "R9";
    req_valid = 1'b1; req_space = 2'd1; req_slot = 2'd0;
    @(negedge clk);
    check(err_stat == 4'h0, "R9 status in reset", err_stat, 0);
    step();
    rst_n = 1'b1;
    step();
    @(negedge clk);
    check(grant == 1'b1, "R9 counters idle after reset", grant, 1);
    step();
    req_valid = 1'b0;

    // every code, single and double size
    for (int f = 0; f < 4; f++) begin
      for (int d = 0; d < 2; d++) begin
        for (int s = 0; s < 4; s += 3) begin
          cur_tag = d ? "R3" : "R2";
          rt_cfg = {4{2'(f)}};
          settle();
          end_cycle(s, d[0], 2'd1);
          wait_count(s, d[0], d[0] ? 2'd2 : 2'd1, n);
          check(n == code_cycles(2'(f)), d ? "R1/R3/R5 pair delay" : "R1/R2/R4 single delay",
                n, code_cycles(2'(f)));
        end
      end
    end

    // single then double on same pair: R5
    cur_tag = "R5";
    rt_cfg = 8'b00_00_01_11;
    settle();
    end_cycle(0, 1'b0, 2'd1);
    wait_count(1, 1'b1, 2'd1, n);
    check(n == 64, "R5 single a then double", n, 64);
    settle();
    end_cycle(1, 1'b0, 2'd2);
    wait_count(0, 1'b1, 2'd2, n);
    check(n == 16, "R5 single b then double", n, 16);

    // double loads both members with own codes: R3
    cur_tag = "R3";
    rt_cfg = 8'b01_10_00_00;
    settle();
    end_cycle(3, 1'b1, 2'd1);
    wait_count(2, 1'b0, 2'd1, n);
    check(n == 32, "R3 pair load slot c", n, 32);
    settle();
    end_cycle(2, 1'b1, 2'd1);
    wait_count(3, 1'b0, 2'd1, n);
    check(n == 16, "R3 pair load slot d", n, 16);
    settle();
    end_cycle(2, 1'b0, 2'd1);
    wait_count(3, 1'b0, 2'd1, n);
    check(n == 0, "R4 neighbour not loaded", n, 0);

    // memory space: R6
    cur_tag = "R6";
    rt_cfg = 8'hFF;
    settle();
    end_cycle(0, 1'b0, 2'd1);
    wait_count(0, 1'b0, 2'd0, n);
    check(n == 0, "R6 mem request while busy", n, 0);
    wait_count(1, 1'b1, 2'd3, n);
    check(n == 0, "R6 reserved request while busy", n, 0);
    settle();
    end_cycle(0, 1'b0, 2'd0);
    wait_count(0, 1'b0, 2'd1, n);
    check(n == 0, "R6 mem done loads nothing", n, 0);
    end_cycle(2, 1'b1, 2'd3);
    wait_count(2, 1'b1, 2'd1, n);
    check(n == 0, "R6 reserved done loads nothing", n, 0);

    // reload while running: R10
    cur_tag = "R10";
    rt_cfg = 8'b00_00_00_11;
    settle();
    end_cycle(0, 1'b0, 2'd1);
    repeat (10) step();
    rt_cfg = 8'b00_00_00_01;
    end_cycle(0, 1'b0, 2'd2);
    wait_count(0, 1'b0, 2'd1, n);
    check(n == 16, "R10 reload from new code", n, 16);

    // no request, no grant: R7
    cur_tag = "R7";
    req_valid = 1'b0; req_space = 2'd0;
    @(negedge clk);
    check(grant == 1'b0, "R7 idle request", grant, 0);
    step();

    // error status: R8
    cur_tag = "R8";
    err_n = 4'b1010;
    repeat (3) step();
    @(negedge clk);
    check(err_stat == 4'b0101, "R8 status pattern a", err_stat, 5);
    step();
    err_n = 4'b0111;
    step();
    @(negedge clk);
    check(err_stat == 4'b0101, "R8 status lag", err_stat, 5);
    step();
    @(negedge clk);
    check(err_stat == 4'b1000, "R8 status pattern b", err_stat, 8);
    step();
    err_n = 4'hF;
    repeat (4) step();

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule